// File: doc/BRIEF.md
# Byte-Port Pseudo-DMA Transfer Engine

This block moves a block of bytes between a byte-addressed memory and a byte-wide peripheral data port, one byte at a time, in either direction. Software first loads a direction bit, an enable/busy bit, a start address and a byte count through a load strobe. It then pulses a start input. The engine walks the address upward and the count downward as bytes complete, so the address and count registers always show how far the transfer has got. When the transfer finishes normally, the busy bit clears and a one-cycle done pulse is raised, which can serve as an interrupt source.

The peripheral needs warning before the last byte. The engine moves all bytes except the final one normally. It then raises its end-of-process output and waits a programmable settling time before it moves the final byte.

A port that is not ready is retried on the same byte. If one byte fails too many times in a row, the transfer stops with progress kept and the busy bit still set, so a second start resumes it. An error response from memory also stops the transfer. In that case the engine raises end-of-process together with a bus-error flag.

At the end of a port-to-memory transfer, normal or aborted, the engine fetches the aligned 32-bit word that contains the current address into a residual register. This lets software recover bytes that sit in a partly filled word.

Top module: `pdma_engine`

## Requirements
- R1: With `ctl_dir`=1 the engine reads memory bytes from the start address upward and presents each one on `prt_wdata` with `prt_we`=1. With `ctl_dir`=0 it takes `prt_rdata` bytes and writes them to memory from the start address upward. Memory and port are never requested in the same cycle.
- R2: A start pulse while `ctl_busy` is 0 has no effect: there is no memory or port request, address and count keep their values, and no done pulse is raised.
- R3: A start pulse with `ctl_busy`=1 and a count of 0 clears `ctl_busy`, raises `done` once and moves no byte. The address is left unchanged.
- R4: Every accepted start clears `bus_err`. It also clears `eop` unless only one byte remains.
- R5: `eop` is 0 while each byte except the last is moved, and 1 when the final byte is moved. At least SETTLE_CYC clock cycles pass between the rise of `eop` and the port transfer of the final byte.
- R6: A port attempt with `prt_rdy`=0 is repeated on the same byte. The attempt limit is reloaded after each byte that succeeds, so up to RETRY_LIMIT-1 refusals per byte still let the transfer complete.
- R7: The RETRY_LIMIT-th consecutive refusal on one byte stops the transfer. The address and count then reflect only the completed bytes, `ctl_busy` stays 1, `eop` and `bus_err` stay 0, and no done pulse is raised.
- R8: An error response from memory stops the transfer at the failing byte. `eop` and `bus_err` both become 1, the address and count still point at that byte, and `ctl_busy` stays 1.
- R9: At the end of a port-to-memory transfer (normal or stopped), `resid` loads the 32-bit word at the current address with its two low bits cleared. The byte at the lowest address goes to bits 31:24. The load is skipped when that aligned address is 0. A memory-to-port transfer never changes `resid`.
- R10: On a normal finish `cur_addr` equals start address plus count, `cur_cnt` is 0, `ctl_busy` is 0, and `done` is high for exactly one cycle.
- R11: A load strobe while a transfer is running is ignored, and the count only ever holds or steps down by one while running.
- R12: A start after a stopped transfer continues from the stored address and remaining count and completes the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Load strobe for direction, busy, address and count (honoured only when idle) |
| ctl_dir_in | input | 1 | Direction to load: 1 memory to port, 0 port to memory |
| ctl_busy_in | input | 1 | Enable/busy bit to load |
| addr_in | input | AW | Start address to load |
| cnt_in | input | CW | Byte count to load |
| start | input | 1 | Transfer request pulse |
| ctl_dir | output | 1 | Current direction bit |
| ctl_busy | output | 1 | Enable/busy bit |
| cur_addr | output | AW | Current address (one past the last byte moved) |
| cur_cnt | output | CW | Remaining byte count |
| eop | output | 1 | End-of-process signal to the peripheral |
| bus_err | output | 1 | Memory error flag |
| resid | output | 32 | Residual aligned word after a port-to-memory transfer |
| done | output | 1 | One-cycle pulse when the busy bit clears |
| active | output | 1 | High while a transfer is in progress |
| mem_req | output | 1 | Memory request, held until ack or error |
| mem_we | output | 1 | Memory request is a byte write |
| mem_word | output | 1 | Memory request is an aligned 32-bit read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 32 | Memory read data (byte reads use bits 7:0) |
| mem_ack | input | 1 | Memory request completed |
| mem_err | input | 1 | Memory request failed |
| prt_try | output | 1 | Port attempt this cycle |
| prt_we | output | 1 | Port attempt is a write to the peripheral |
| prt_wdata | output | 8 | Byte to the peripheral |
| prt_rdata | input | 8 | Byte from the peripheral |
| prt_rdy | input | 1 | Peripheral accepts or supplies the byte this cycle |

## Verification
The hardest case to reach is a stop in the middle of a block, followed by a resume. It needs exactly RETRY_LIMIT refusals on a single byte, or an error response timed to one particular memory address. It also needs the address, count and flags to stay intact until a second start picks them up. The bench model refuses port attempts from a per-byte schedule and raises the memory error on a chosen address. This lets directed runs stop at a known byte: one refusal short of the limit, at the limit, and at a memory error during a port-to-memory run whose residual word mixes new and old bytes. A plain second start then resumes each run. Random runs around these cases vary direction, length, alignment, port refusals and memory wait states.

// File: rtl/pdma_pkg.sv
// Shared types for the pseudo-DMA engine.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package pdma_pkg;

    // Sequencer states of the transfer engine
    typedef enum logic [2:0] {
        S_IDLE,
        S_MRD,
        S_PORT,
        S_MWR,
        S_SETTLE,
        S_END,
        S_RESID,
        S_FIN
    } pdma_state_t;

endpackage

// File: rtl/pdma_retry.sv
// Per-byte attempt limiter. Counts refused port attempts and flags the
// attempt that uses up the limit.
// Assumes: LIMIT >= 1; reload has priority over fail.
module pdma_retry #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic fail,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] left_q;

    // Attempts remaining for the current byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= W'(LIMIT);
        end else if (reload) begin
            left_q <= W'(LIMIT);
        end else if (fail && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expired = fail && (left_q == W'(1));
endmodule

// File: rtl/pdma_settle.sv
// One-shot settling timer. A start pulse arms it, and done is high in the
// CYCLES-th cycle after the start edge.
// Assumes: CYCLES >= 1; a start while running restarts the count.
module pdma_settle #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_q;
    logic         run_q;

    // Down-count from the load value while armed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= W'(CYCLES - 1);
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run_q && (cnt_q == '0);
endmodule

// File: rtl/pdma_engine.sv
// Byte-port pseudo-DMA engine. Moves cur_cnt bytes between memory and a
// byte-wide peripheral port. Raises eop and waits SETTLE_CYC cycles before
// the final byte, retries refused port attempts up to RETRY_LIMIT per byte,
// and stops on a memory error. On port-to-memory runs it fetches the aligned
// residual word at the end.
// Assumes: memory holds mem_ack/mem_err low until it answers a held
// mem_req; the port answers a prt_try in the same cycle via prt_rdy;
// AW >= 3.
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int AW          = 16,
    parameter int CW          = 16,
    parameter int RETRY_LIMIT = 100,
    parameter int SETTLE_CYC  = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_dir_in,
    input  logic          ctl_busy_in,
    input  logic [AW-1:0] addr_in,
    input  logic [CW-1:0] cnt_in,
    input  logic          start,
    output logic          ctl_dir,
    output logic          ctl_busy,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_cnt,
    output logic          eop,
    output logic          bus_err,
    output logic [31:0]   resid,
    output logic          done,
    output logic          active,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          prt_try,
    output logic          prt_we,
    output logic [7:0]    prt_wdata,
    input  logic [7:0]    prt_rdata,
    input  logic          prt_rdy
);
    pdma_state_t   state_q;
    pdma_state_t   first_st;
    logic          dir_q, busy_q, eop_q, berr_q, done_q, last_q, abort_q;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic [31:0]   resid_q;
    logic [7:0]    buf_q;
    logic          launch, port_ok, port_fail, mem_ok, byte_done;
    logic          settle_go, settle_done, retry_reload, retry_exp;

    // Handshake decode for the current state
    always_comb begin
        first_st  = dir_q ? S_MRD : S_PORT;
        launch    = (state_q == S_IDLE) && !ctl_wr && start && busy_q && (cnt_q != '0);
        port_ok   = (state_q == S_PORT) && prt_rdy;
        port_fail = (state_q == S_PORT) && !prt_rdy;
        mem_ok    = mem_ack && !mem_err;
        byte_done = (port_ok && dir_q) || ((state_q == S_MWR) && mem_ok);
        settle_go = (launch && cnt_q == CW'(1))
                 || (byte_done && !last_q && cnt_q == CW'(2));
        retry_reload = (state_q == S_IDLE) || port_ok;
    end

    pdma_retry #(.LIMIT(RETRY_LIMIT)) i_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (retry_reload),
        .fail    (port_fail),
        .expired (retry_exp)
    );

    pdma_settle #(.CYCLES(SETTLE_CYC)) i_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .start (settle_go),
        .done  (settle_done)
    );

    // Transfer sequencer and register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dir_q   <= 1'b0;
            busy_q  <= 1'b0;
            addr_q  <= '0;
            cnt_q   <= '0;
            eop_q   <= 1'b0;
            berr_q  <= 1'b0;
            resid_q <= '0;
            done_q  <= 1'b0;
            buf_q   <= '0;
            last_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (ctl_wr) begin
                        dir_q  <= ctl_dir_in;
                        busy_q <= ctl_busy_in;
                        addr_q <= addr_in;
                        cnt_q  <= cnt_in;
                    end else if (start && busy_q) begin
                        if (cnt_q == '0) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            eop_q   <= (cnt_q == CW'(1));
                            berr_q  <= 1'b0;
                            abort_q <= 1'b0;
                            last_q  <= (cnt_q == CW'(1));
                            state_q <= (cnt_q == CW'(1)) ? S_SETTLE : first_st;
                        end
                    end
                end
                S_MRD: begin
                    if (mem_err) begin
                        eop_q   <= 1'b1;
                        berr_q  <= 1'b1;
                        abort_q <= 1'b1;
                        state_q <= S_END;
                    end else if (mem_ack) begin
                        buf_q   <= mem_rdata[7:0];
                        state_q <= S_PORT;
                    end
                end
                S_PORT: begin
                    if (prt_rdy) begin
                        if (!dir_q) begin
                            buf_q   <= prt_rdata;
                            state_q <= S_MWR;
                        end
                    end else if (retry_exp) begin
                        abort_q <= 1'b1;
                        state_q <= S_END;
                    end
                end
                S_MWR: begin
                    if (mem_err) begin
                        eop_q   <= 1'b1;
                        berr_q  <= 1'b1;
                        abort_q <= 1'b1;
                        state_q <= S_END;
                    end
                end
                S_SETTLE: begin
                    if (settle_done) begin
                        last_q  <= 1'b1;
                        state_q <= first_st;
                    end
                end
                S_END: begin
                    state_q <= (!dir_q && addr_q[AW-1:2] != '0) ? S_RESID : S_FIN;
                end
                S_RESID: begin
                    if (mem_err) begin
                        state_q <= S_FIN;
                    end else if (mem_ack) begin
                        resid_q <= mem_rdata;
                        state_q <= S_FIN;
                    end
                end
                S_FIN: begin
                    if (!abort_q) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase

            if (byte_done) begin
                addr_q <= addr_q + 1'b1;
                cnt_q  <= cnt_q - 1'b1;
                if (last_q) begin
                    state_q <= S_END;
                end else if (cnt_q == CW'(2)) begin
                    eop_q   <= 1'b1;
                    state_q <= S_SETTLE;
                end else begin
                    state_q <= first_st;
                end
            end
        end
    end

    // Output mapping
    always_comb begin
        ctl_dir   = dir_q;
        ctl_busy  = busy_q;
        cur_addr  = addr_q;
        cur_cnt   = cnt_q;
        eop       = eop_q;
        bus_err   = berr_q;
        resid     = resid_q;
        done      = done_q;
        active    = (state_q != S_IDLE);
        mem_req   = (state_q == S_MRD) || (state_q == S_MWR) || (state_q == S_RESID);
        mem_we    = (state_q == S_MWR);
        mem_word  = (state_q == S_RESID);
        mem_addr  = (state_q == S_RESID) ? {addr_q[AW-1:2], 2'b00} : addr_q;
        mem_wdata = buf_q;
        prt_try   = (state_q == S_PORT);
        prt_we    = dir_q;
        prt_wdata = buf_q;
    end
endmodule

// File: rtl/pdma_engine_chk.sv
// Protocol and state checks for pdma_engine, attached with bind.
// Assumes: it observes only ports of the engine.
module pdma_engine_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_busy,
    input logic          ctl_dir,
    input logic [CW-1:0] cur_cnt,
    input logic          eop,
    input logic          bus_err,
    input logic          done,
    input logic          active,
    input logic          mem_req,
    input logic          mem_word,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          mem_err,
    input logic          prt_try
);
    p_never_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && prt_try));

    p_req_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr)));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!mem_req && !prt_try));

    p_berr_with_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> eop);

    p_resid_read_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_word |-> !ctl_dir);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ctl_busy && !active));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (cur_cnt == $past(cur_cnt) || cur_cnt == $past(cur_cnt) - CW'(1)));
endmodule

bind pdma_engine pdma_engine_chk #(.AW(AW), .CW(CW)) i_pdma_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_busy (ctl_busy),
    .ctl_dir  (ctl_dir),
    .cur_cnt  (cur_cnt),
    .eop      (eop),
    .bus_err  (bus_err),
    .done     (done),
    .active   (active),
    .mem_req  (mem_req),
    .mem_word (mem_word),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .prt_try  (prt_try)
);

// File: tb/test_pdma_engine.sv
`timescale 1ns/1ps
// Self-checking bench for pdma_engine: behavioural memory and port models,
// directed corner cases and seeded random transfers.
module test_pdma_engine;
    localparam int AW  = 16;
    localparam int CW  = 16;
    localparam int RL  = 100;
    localparam int SET = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0, ctl_dir_in = 1'b0, ctl_busy_in = 1'b0, start = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [CW-1:0] cnt_in = '0;
    logic          ctl_dir, ctl_busy, eop, bus_err, done, active;
    logic [AW-1:0] cur_addr, mem_addr;
    logic [CW-1:0] cur_cnt;
    logic [31:0]   resid;
    logic          mem_req, mem_we, mem_word, prt_try, prt_we;
    logic [7:0]    mem_wdata, prt_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0, mem_err = 1'b0, prt_rdy = 1'b0;
    logic [7:0]    prt_rdata = '0;

    pdma_engine #(.AW(AW), .CW(CW), .RETRY_LIMIT(RL), .SETTLE_CYC(SET)) i_pdma_engine (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_dir_in(ctl_dir_in),
        .ctl_busy_in(ctl_busy_in), .addr_in(addr_in), .cnt_in(cnt_in), .start(start),
        .ctl_dir(ctl_dir), .ctl_busy(ctl_busy), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
        .eop(eop), .bus_err(bus_err), .resid(resid), .done(done), .active(active),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .prt_try(prt_try), .prt_we(prt_we), .prt_wdata(prt_wdata), .prt_rdata(prt_rdata),
        .prt_rdy(prt_rdy)
    );

    always #10 clk = ~clk;

    logic [7:0] mem [0:1023];
    logic [7:0] src [0:63];
    int         stalls [0:63];
    logic [7:0] rec_data [0:63];
    logic       rec_eop [0:63];
    int         rec_cyc [0:63];
    int idx, cur_stall, cyc, eop_rise, done_cnt, idle_act, mem_wait, wait_ctr;
    int n_cmp, n_bad;
    bit eop_seen, err_en, timed_out;
    logic [AW-1:0] err_addr;
    logic [31:0]   exp_resid;

    function automatic logic [31:0] word_at(input logic [AW-1:0] a);
        logic [9:0] b = {a[9:2], 2'b00};
        return {mem[b], mem[b + 10'd1], mem[b + 10'd2], mem[b + 10'd3]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: wait for the falling edge, then answer the design's requests
    task automatic cyc_step();
        @(negedge clk);
        cyc++;
        if (cyc > 150000) timed_out = 1;
        if (done) done_cnt++;
        if (eop && !eop_seen) begin eop_seen = 1; eop_rise = cyc; end
        if (!active && (mem_req || prt_try)) idle_act++;
        prt_rdy = 1'b0;
        if (prt_try) begin
            if (idx < 64 && cur_stall < stalls[idx]) begin
                cur_stall++;
            end else begin
                prt_rdy = 1'b1;
                if (idx < 64) begin
                    prt_rdata     = src[idx];
                    rec_data[idx] = prt_we ? prt_wdata : src[idx];
                    rec_eop[idx]  = eop;
                    rec_cyc[idx]  = cyc;
                end
                idx++;
                cur_stall = 0;
            end
        end
        mem_ack = 1'b0;
        mem_err = 1'b0;
        if (mem_req) begin
            if (wait_ctr < mem_wait) begin
                wait_ctr++;
            end else begin
                wait_ctr = 0;
                if (err_en && !mem_word && mem_addr == err_addr) begin
                    mem_err = 1'b1;
                end else begin
                    mem_ack = 1'b1;
                    if (mem_word)     mem_rdata = word_at(mem_addr);
                    else if (mem_we)  mem[mem_addr[9:0]] = mem_wdata;
                    else              mem_rdata = {24'h0, mem[mem_addr[9:0]]};
                end
            end
        end
    endtask

    task automatic load(input logic d, input logic b, input logic [AW-1:0] a, input logic [CW-1:0] n);
        ctl_wr = 1'b1; ctl_dir_in = d; ctl_busy_in = b; addr_in = a; cnt_in = n;
        cyc_step();
        ctl_wr = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        cyc_step();
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000 && active && !timed_out; k++) cyc_step();
        if (active) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog: active actual 1 expected 0");
        end
    endtask

    task automatic reset_log(input int maxst);
        idx = 0; cur_stall = 0; eop_seen = 0; done_cnt = 0; wait_ctr = 0;
        for (int i = 0; i < 64; i++) begin
            src[i] = 8'($urandom);
            if (maxst >= 0) stalls[i] = $urandom_range(maxst, 0);
        end
    endtask

    // Full transfer with checks of data, eop timing, final registers and residual
    task automatic run_normal(input logic d, input logic [AW-1:0] base, input int n,
                              input int maxst, input bit poke);
        logic [7:0] exp_b [0:63];
        int bad;
        for (int i = 0; i < n; i++) exp_b[i] = mem[base[9:0] + 10'(i)];
        reset_log(maxst);
        load(d, 1'b1, base, CW'(n));
        pulse_start();
        if (poke) begin
            cyc_step();
            load(~d, 1'b0, 16'h0123, 16'h0007);
        end
        wait_idle();
        chk("R10 address one past last byte", cur_addr, base + AW'(n));
        chk("R10 count zero", cur_cnt, 0);
        chk("R10 busy cleared", ctl_busy, 0);
        chk("R10 one done pulse", done_cnt, 1);
        chk("R1 bytes moved", idx, n);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (d) begin if (rec_data[i] !== exp_b[i]) bad++; end
            else   begin if (mem[base[9:0] + 10'(i)] !== src[i]) bad++; end
        end
        chk(d ? "R1 memory to port data" : "R1 port to memory data", bad, 0);
        bad = 0;
        for (int i = 0; i < n; i++) if (rec_eop[i] !== (i == n - 1)) bad++;
        chk("R5 eop only on final byte", bad, 0);
        chk("R5 settle gap respected", (rec_cyc[n-1] - eop_rise) >= SET, 1);
        if (!d && ((base + AW'(n)) & ~AW'(3)) != 0) exp_resid = word_at(base + AW'(n));
        chk("R9 residual word", resid, exp_resid);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        n_cmp = 0; n_bad = 0; cyc = 0; mem_wait = 0; err_en = 0; err_addr = '0;
        timed_out = 0; idle_act = 0; exp_resid = '0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
        reset_log(0);
        repeat (3) cyc_step();
        rst_n = 1'b1;
        cyc_step();

        // Reset state
        chk("R10 reset busy", ctl_busy, 0);
        chk("R10 reset count", cur_cnt, 0);
        chk("R4 reset eop", eop, 0);
        chk("R8 reset bus error", bus_err, 0);
        chk("R2 reset idle", active, 0);

        // R2: start with busy clear does nothing
        reset_log(0);
        load(1'b0, 1'b0, 16'd60, 16'd5);
        pulse_start();
        repeat (30) cyc_step();
        chk("R2 no requests", idle_act + idx, 0);
        chk("R2 count kept", cur_cnt, 5);
        chk("R2 address kept", cur_addr, 60);
        chk("R2 no done", done_cnt, 0);

        // R3: zero count
        reset_log(0);
        load(1'b1, 1'b1, 16'd50, 16'd0);
        pulse_start();
        repeat (5) cyc_step();
        chk("R3 busy cleared", ctl_busy, 0);
        chk("R3 one done", done_cnt, 1);
        chk("R3 address kept", cur_addr, 50);
        chk("R3 no bytes", idx, 0);

        // Directed single-byte transfers both ways
        run_normal(1'b1, 16'd300, 1, 0, 0);
        run_normal(1'b0, 16'd305, 1, 0, 0);

        // R9: aligned end address of zero skips the residual load
        run_normal(1'b0, 16'd0, 3, 1, 0);
        run_normal(1'b0, 16'd1, 2, 0, 0);

        // R11: load strobe while running is ignored
        run_normal(1'b1, 16'd400, 6, 1, 1);

        // R6: one refusal short of the limit on a byte still completes
        for (int i = 0; i < 64; i++) stalls[i] = 0;
        stalls[2] = RL - 1;
        stalls[3] = RL - 1;
        run_normal(1'b1, 16'd500, 5, -1, 0);

        // R7: the limit-th refusal stops the transfer, then R12 resumes it
        for (int i = 0; i < 64; i++) stalls[i] = 0;
        stalls[4] = RL;
        reset_log(-1);
        load(1'b1, 1'b1, 16'd100, 16'd10);
        pulse_start();
        wait_idle();
        chk("R7 count keeps remaining", cur_cnt, 6);
        chk("R7 address at stalled byte", cur_addr, 104);
        chk("R7 busy stays set", ctl_busy, 1);
        chk("R7 no done", done_cnt, 0);
        chk("R7 eop not raised", eop, 0);
        chk("R7 no bus error", bus_err, 0);
        reset_log(0);
        pulse_start();
        wait_idle();
        chk("R12 resumed address", cur_addr, 110);
        chk("R12 resumed count", cur_cnt, 0);
        chk("R12 done after resume", done_cnt, 1);
        chk("R12 remaining bytes", idx, 6);
        chk("R12 first resumed byte", rec_data[0], mem[104]);

        // R8: memory error on a port-to-memory write
        reset_log(0);
        err_en = 1; err_addr = 16'd203;
        load(1'b0, 1'b1, 16'd200, 16'd8);
        pulse_start();
        wait_idle();
        chk("R8 eop raised", eop, 1);
        chk("R8 bus error raised", bus_err, 1);
        chk("R8 address at failing byte", cur_addr, 203);
        chk("R8 count at failing byte", cur_cnt, 5);
        chk("R8 busy stays set", ctl_busy, 1);
        chk("R8 no done", done_cnt, 0);
        exp_resid = word_at(16'd200);
        chk("R9 residual after stop", resid, exp_resid);
        err_en = 0;
        reset_log(0);
        pulse_start();
        chk("R4 eop cleared at start", eop, 0);
        chk("R4 bus error cleared at start", bus_err, 0);
        wait_idle();
        chk("R12 resume after error", cur_addr, 208);
        chk("R12 resume data", mem[203], src[0]);
        exp_resid = word_at(16'd208);
        chk("R9 residual after resume", resid, exp_resid);

        // Seeded random transfers
        for (int t = 0; t < 14 && !timed_out; t++) begin
            mem_wait = $urandom_range(2, 0);
            run_normal(1'($urandom), AW'($urandom_range(900, 4)),
                       $urandom_range(24, 1), $urandom_range(3, 0), 0);
        end

        if (timed_out) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog: cycles actual %0d expected below 150000", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule